// File: doc/BRIEF.md
# Double-Buffered Dual-Channel Converter Register Bank

This block is the digital front end of a two-channel, 16-bit parallel-input digital-to-analog converter, rebuilt as synchronous logic. A host drives an active-low chip select, a read/write line, a channel select, an update strobe, a preset strobe and a 16-bit data bus. All of these are brought into the system clock domain through synchronizer stages, and the block then acts on their edges.

Each channel has two registers in series. The staging register is written and read back by the host, one channel at a time. The output register supplies the channel's code to the converter core. Writing a staging register leaves the outputs alone. One rising edge of the update strobe copies both staging registers into both output registers in the same clock, so the two channels change together.

A rising edge of the preset strobe loads all four registers with a fixed code. That code is midscale (16'h8000) or zero (16'h0000), chosen by a parameter. Codes are straight binary with bit 15 as the MSB. A code N stands for the low reference plus N/65536 of the span between the references.

Top module: `dual_dac_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released, all four registers hold the preset code: 16'h8000 when `RESET_MIDSCALE`=1, 16'h0000 when it is 0.
- R2: A write cycle has `cs_n` low with `rw` low (0 = write). When `cs_n` then rises, the value on `data_in` is stored in the staging register of the channel chosen by `ch_sel` (0 = channel A, 1 = channel B). The value and channel used are those sampled while `cs_n` was low. The other channel's staging register does not change.
- R3: `data_oe` is 1 only while `cs_n` is low and `rw` is high. During that time `data_out` shows the staging register chosen by `ch_sel`. In every other state `data_oe` is 0.
- R4: A staging-register write does not change `code_a` or `code_b`.
- R5: A low-to-high transition of `upd_stb` copies both staging registers into both output registers in the same clock. Holding `upd_stb` high copies nothing more.
- R6: A low-to-high transition of `preset_stb` loads all four registers with the preset code. Holding `preset_stb` high does not block later writes.
- R7: If preset and update edges are detected in the same clock, the preset wins and the outputs take the preset code.
- R8: A read cycle (`cs_n` low with `rw` high) ended by `cs_n` rising changes no register.
- R9: The output registers change only in the clock after a detected update or preset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read back, 0 = write |
| ch_sel | input | 1 | 0 = channel A, 1 = channel B |
| upd_stb | input | 1 | Update strobe; rising edge copies staging to output registers |
| preset_stb | input | 1 | Preset strobe; rising edge loads the preset code into all registers |
| data_in | input | 16 | Host data bus, write direction |
| data_out | output | 16 | Host data bus, read direction |
| data_oe | output | 1 | Drive enable for the read direction of the bus |
| code_a | output | 16 | Channel A output register |
| code_b | output | 16 | Channel B output register |

## Verification
The hardest case to reach from the ports is a preset edge and an update edge detected in the same clock. Both strobes pass through matching synchronizer chains, so the bench raises them on the same falling clock edge, and their edges then line up inside the block. The bench also holds each strobe high while it issues writes. This shows that a level does nothing further, that output codes do not move, and that staging-register readback still follows the writes.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } ch_e;

  function automatic logic [31:0] preset_code(input bit midscale, input int unsigned width);
    logic [31:0] v;
    v = '0;
    if (midscale) v[width-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
  import dacbank_pkg::*;
#(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              rw_s,
  input  logic              sel_s,
  input  logic              upd_s,
  input  logic              preset_s,
  input  logic [CODE_W-1:0] data_s,
  output logic [NUM_CH-1:0] wr_en,
  output logic [CODE_W-1:0] wr_data,
  output logic              load_evt,
  output logic              preset_evt,
  output logic              rd_oe
);
  logic              cs_prev_q, upd_prev_q, pre_prev_q;
  logic              hold_rw_q, hold_rw_d;
  logic              hold_sel_q, hold_sel_d;
  logic [CODE_W-1:0] hold_data_q, hold_data_d;
  logic              cs_release;
  logic              hold_en;

  assign cs_release = cs_n_s & ~cs_prev_q;
  assign hold_en    = ~cs_n_s;
  assign preset_evt = preset_s & ~pre_prev_q;
  assign load_evt   = upd_s & ~upd_prev_q;
  assign rd_oe      = ~cs_n_s & rw_s;
  assign wr_data    = hold_data_q;

  always_comb begin
    hold_rw_d   = hold_rw_q;
    hold_sel_d  = hold_sel_q;
    hold_data_d = hold_data_q;
    if (hold_en) begin
      hold_rw_d   = rw_s;
      hold_sel_d  = sel_s;
      hold_data_d = data_s;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_wr
      assign wr_en[c] = cs_release & ~hold_rw_q & ~preset_evt & (hold_sel_q == c[0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      upd_prev_q  <= 1'b0;
      pre_prev_q  <= 1'b0;
      hold_rw_q   <= 1'b1;
      hold_sel_q  <= CH_A;
      hold_data_q <= '0;
    end else begin
      cs_prev_q   <= cs_n_s;
      upd_prev_q  <= upd_s;
      pre_prev_q  <= preset_s;
      hold_rw_q   <= hold_rw_d;
      hold_sel_q  <= hold_sel_d;
      hold_data_q <= hold_data_d;
    end
  end

  p_wr_on_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> (cs_n_s && !$past(cs_n_s)));
  p_one_channel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && rw_s) |=> !(|wr_en));
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int unsigned     CODE_W   = 16,
  parameter logic [CODE_W-1:0] RST_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              load_evt,
  input  logic              preset_evt,
  output logic [CODE_W-1:0] stage_q,
  output logic [CODE_W-1:0] out_q
);
  logic [CODE_W-1:0] stage_d, out_d;
  logic              stage_en, out_en;

  assign stage_en = preset_evt | wr_en;
  assign out_en   = preset_evt | load_evt;

  always_comb begin
    stage_d = stage_q;
    out_d   = out_q;
    if (preset_evt) begin
      stage_d = RST_CODE;
      out_d   = RST_CODE;
    end else begin
      if (wr_en)    stage_d = wr_data;
      if (load_evt) out_d   = stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= RST_CODE;
      out_q   <= RST_CODE;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (out_en)   out_q   <= out_d;
    end
  end

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !preset_evt) |=> $stable(out_q));
  p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !preset_evt) |=> (out_q == $past(stage_q)));
  p_preset_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    preset_evt |=> (out_q == RST_CODE && stage_q == RST_CODE));
  p_preset_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_evt && load_evt) |=> (out_q == RST_CODE));
  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !preset_evt) |=> $stable(stage_q));
endmodule

// File: rtl/dual_dac_regbank.sv
module dual_dac_regbank
  import dacbank_pkg::*;
#(
  parameter int unsigned CODE_W         = 16,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter bit          RESET_MIDSCALE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              ch_sel,
  input  logic              upd_stb,
  input  logic              preset_stb,
  input  logic [CODE_W-1:0] data_in,
  output logic [CODE_W-1:0] data_out,
  output logic              data_oe,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  localparam logic [31:0]       PRESET_FULL = preset_code(RESET_MIDSCALE, CODE_W);
  localparam logic [CODE_W-1:0] PRESET      = PRESET_FULL[CODE_W-1:0];
  localparam int unsigned       CTL_W       = 5;

  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [CTL_W-1:0]  ctl_raw, ctl_s;
  logic [CODE_W-1:0] data_s;
  logic              cs_n_s, rw_s, sel_s, upd_s, preset_s;
  logic [NUM_CH-1:0] wr_en;
  logic [CODE_W-1:0] wr_data;
  logic              load_evt, preset_evt, rd_oe;
  logic [CODE_W-1:0] stage_q [NUM_CH];
  logic [CODE_W-1:0] out_q   [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign ctl_raw = {cs_n, rw, ch_sel, upd_stb, preset_stb};

  dacbank_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b11000)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n_int), .d(ctl_raw), .q(ctl_s));

  dacbank_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n_int), .d(data_in), .q(data_s));

  assign {cs_n_s, rw_s, sel_s, upd_s, preset_s} = ctl_s;

  dacbank_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int),
    .cs_n_s(cs_n_s), .rw_s(rw_s), .sel_s(sel_s), .upd_s(upd_s), .preset_s(preset_s),
    .data_s(data_s), .wr_en(wr_en), .wr_data(wr_data),
    .load_evt(load_evt), .preset_evt(preset_evt), .rd_oe(rd_oe));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dacbank_chan #(.CODE_W(CODE_W), .RST_CODE(PRESET)) u_chan (
        .clk(clk), .rst_n(rst_n_int),
        .wr_en(wr_en[c]), .wr_data(wr_data),
        .load_evt(load_evt), .preset_evt(preset_evt),
        .stage_q(stage_q[c]), .out_q(out_q[c]));
    end
  endgenerate

  assign data_oe  = rd_oe;
  assign data_out = rd_oe ? stage_q[sel_s] : '0;
  assign code_a   = out_q[CH_A];
  assign code_b   = out_q[CH_B];

  p_reset_code_r1: assert property (@(posedge clk)
    !rst_n_int |=> (!rst_n_int || (code_a == PRESET && code_b == PRESET)));
  p_oe_only_read_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    data_oe |-> (!cs_n_s && rw_s));
  p_joint_update_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    $changed(code_a) |-> ($past(load_evt) || $past(preset_evt)));
endmodule

// File: tb/dual_dac_regbank_tb.sv
module dual_dac_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, cs_n, rw, ch_sel, upd_stb, preset_stb;
  logic [15:0] data_in;
  logic [15:0] dout_m, dout_z, ca_m, cb_m, ca_z, cb_z;
  logic oe_m, oe_z;
  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] st_m [2];
  logic [15:0] st_z [2];
  logic [15:0] oc_m [2];
  logic [15:0] oc_z [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_regbank #(.RESET_MIDSCALE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ch_sel(ch_sel),
    .upd_stb(upd_stb), .preset_stb(preset_stb), .data_in(data_in),
    .data_out(dout_m), .data_oe(oe_m), .code_a(ca_m), .code_b(cb_m));

  dual_dac_regbank #(.RESET_MIDSCALE(1'b0)) dut_z (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ch_sel(ch_sel),
    .upd_stb(upd_stb), .preset_stb(preset_stb), .data_in(data_in),
    .data_out(dout_z), .data_oe(oe_z), .code_a(ca_z), .code_b(cb_z));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_codes(input string tag);
    chk({tag, " code_a mid"}, ca_m, oc_m[0]);
    chk({tag, " code_b mid"}, cb_m, oc_m[1]);
    chk({tag, " code_a zero"}, ca_z, oc_z[0]);
    chk({tag, " code_b zero"}, cb_z, oc_z[1]);
  endtask

  task automatic do_write(input int ch, input logic [15:0] v);
    ch_sel = ch[0]; rw = 1'b0; data_in = v; cs_n = 1'b0;
    waitn(3);
    chk("R3 oe low during write", {15'd0, oe_m}, 16'd0);
    cs_n = 1'b1;
    waitn(4);
    st_m[ch] = v; st_z[ch] = v;
  endtask

  task automatic do_read(input string tag, input int ch);
    ch_sel = ch[0]; rw = 1'b1; data_in = 16'hDEAD; cs_n = 1'b0;
    waitn(4);
    chk({tag, " oe mid"}, {15'd0, oe_m}, 16'd1);
    chk({tag, " data mid"}, dout_m, st_m[ch]);
    chk({tag, " data zero"}, dout_z, st_z[ch]);
    cs_n = 1'b1;
    waitn(4);
    chk({tag, " oe idle"}, {15'd0, oe_m}, 16'd0);
  endtask

  task automatic do_load();
    upd_stb = 1'b1; waitn(4); upd_stb = 1'b0; waitn(4);
    oc_m = st_m; oc_z = st_z;
  endtask

  task automatic model_preset();
    st_m[0] = 16'h8000; st_m[1] = 16'h8000; oc_m[0] = 16'h8000; oc_m[1] = 16'h8000;
    st_z[0] = 16'h0000; st_z[1] = 16'h0000; oc_z[0] = 16'h0000; oc_z[1] = 16'h0000;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; cs_n = 1'b1; rw = 1'b1; ch_sel = 1'b0;
    upd_stb = 1'b0; preset_stb = 1'b0; data_in = '0;
    model_preset();
    waitn(3);
    chk_codes("R1 in reset");
    rst_n = 1'b1;
    waitn(5);
    chk_codes("R1 after release");
    do_read("R1 readback A", 0);
    do_read("R1 readback B", 1);

    // R2/R3/R4 sweep of walking patterns on both channels, R5 loads in between
    for (int b = 0; b < 16; b++) begin
      do_write(0, 16'h0001 << b);
      do_write(1, ~(16'h0001 << b));
      chk_codes("R4 codes unchanged by write");
      do_read("R2 R3 readback A", 0);
      do_read("R2 R3 readback B", 1);
      if (b % 4 == 3) begin
        do_load();
        chk_codes("R5 joint update");
      end
    end

    // R2 other channel untouched
    do_write(0, 16'hA5A5);
    do_read("R2 B untouched", 1);

    // R5 held strobe does not recopy
    upd_stb = 1'b1; waitn(4);
    oc_m = st_m; oc_z = st_z;
    chk_codes("R5 first edge");
    do_write(0, 16'h1234);
    do_write(1, 16'hFEDC);
    waitn(4);
    chk_codes("R5 level no recopy");
    upd_stb = 1'b0; waitn(4);
    do_load();
    chk_codes("R5 second edge");

    // R8 read cycle changes nothing
    do_read("R8 read A", 0);
    do_read("R8 read A again", 0);
    chk_codes("R8 codes");

    // R6 preset edge, then held high while writing
    do_write(0, 16'h0F0F);
    preset_stb = 1'b1; waitn(4);
    model_preset();
    chk_codes("R6 preset codes");
    do_read("R6 preset stage A", 0);
    do_read("R6 preset stage B", 1);
    do_write(1, 16'h7777);
    do_read("R6 write while held", 1);
    preset_stb = 1'b0; waitn(4);

    // R7 preset and update together
    do_write(0, 16'h3C3C);
    do_write(1, 16'hC3C3);
    upd_stb = 1'b1; preset_stb = 1'b1; waitn(4);
    model_preset();
    chk_codes("R7 preset wins");
    upd_stb = 1'b0; preset_stb = 1'b0; waitn(4);
    chk_codes("R7 after release");
    do_read("R7 stage A", 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule